// File: doc/BRIEF.md
# Daisy-Chain Addressable SMBus Register Target

This block is a two-wire bus target that serves a small 8-bit register file. It watches the SCL and SDA lines through its own synchronizers and finds START and STOP conditions in the sampled stream. It drives SDA only through an open-drain enable. A host writes one register with a pointer byte followed by a data byte. To read, the host writes the pointer, issues a repeated START, addresses the device for reading and takes one byte.

Every copy of the block comes out of reset answering the same 7-bit address. Writing register 0 loads a new address from bits 7:1 of the data byte and raises a chain output. That output holds the next device in a chain in reset until the current one has its own address. A host can therefore give unique addresses to any number of identical devices that share one bus, one device at a time, with a single reset line.

Register 0 holds the address. Register 1 is read-only and reflects a status input. Registers 2 up to `NREGS-1` are read/write control bytes that appear on `ctrl_o`. Pointers at or above `NREGS` are acknowledged, read as zero and ignore writes.

Top module: `smbus_chain_target`

## Requirements
- R1: After reset the device acknowledges address 7'h17, so write byte 8'h2E and read byte 8'h2F, and `chain_out` is low.
- R2: A write sequence (START, address+W, pointer, data, STOP) is acknowledged on all three bytes, and the addressed read/write register takes the data byte.
- R3: A combined read (START, address+W, pointer, repeated START, address+R, one byte, master NACK, STOP) returns the addressed register MSB first, and the device releases SDA for the master's acknowledge bit.
- R4: Writing register 0 makes bits 7:1 of the data byte the device address. Later transactions to the old address are not acknowledged, and reading register 0 returns {address, 1'b0}.
- R5: `chain_out` rises when register 0 is written and stays high until `rst_n` goes low.
- R6: While `rst_n` is low, every register returns to its default (address 7'h17, control bytes 8'h00) and `chain_out` is forced low.
- R7: A transaction whose address byte does not match gets no acknowledge, and no later byte is acknowledged or has any effect until the next START.
- R8: A write to register 1 or to any pointer at or above `NREGS` is acknowledged but changes nothing. A read of a pointer at or above `NREGS` returns 8'h00, and a read of register 1 returns `status_i`.
- R9: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A STOP ends any transaction, and a repeated START restarts the address phase.
- R10: If SCL and SDA both stay high for `IDLE_CYC` clock cycles, any transaction in progress is abandoned, and later bits are ignored until a START.
- R11: `sda_oe` is asserted only during acknowledge bits the device gives and during zero bits of read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low reset-in from the host or the previous device in the chain |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | Pulls SDA low when 1; SDA is released when 0 |
| status_i | input | 8 | Value returned by read-only register 1 |
| ctrl_o | output | 8*(NREGS-2) | Control registers 2..NREGS-1, register 2 in the low byte |
| chain_out | output | 1 | Reset-out to the next device in the chain |

## Verification
A wrong bit counter or state shows up at the next acknowledge slot. There the device either fails to pull SDA low or pulls it low one bit early, and a read returns a shifted byte. Both appear within the same byte at the bus pins. A wrong address register is visible on the very next transaction, which is then acknowledged or refused wrongly. A lost chain-output or register value is visible in `chain_out`, `ctrl_o` or a read-back within one transaction.

// File: rtl/smbus_chain_target.sv
module smbus_chain_target #(
  parameter int          NREGS    = 8,
  parameter logic [6:0]  DEF_ADDR = 7'h17,
  parameter int          IDLE_CYC = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  input  logic [7:0]             status_i,
  output logic [8*(NREGS-2)-1:0] ctrl_o,
  output logic                   chain_out
);
  localparam int IW = $clog2(IDLE_CYC + 1);
  localparam int AW = $clog2(NREGS);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_PTR, S_PACK, S_WDAT, S_WACK, S_RDAT, S_RACK, S_IGNORE
  } state_t;

  state_t      st;
  logic [2:0]  scl_sy, sda_sy;
  logic [3:0]  bitn;
  logic [7:0]  sh, ptr;
  logic        rw;
  logic [6:0]  dev_addr;
  logic [IW-1:0] idle_cnt;
  logic [7:0]  regs [2:NREGS-1];

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire scl_q = scl_sy[2];
  wire sda_q = sda_sy[2];

  wire rise     = scl_s & ~scl_q;
  wire fall     = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire idle_hit  = (idle_cnt == IW'(IDLE_CYC - 1)) & scl_s & sda_s;
  wire byte_end  = fall & (bitn == 4'd8);

  wire ptr_rw  = (ptr >= 8'd2) && (ptr < 8'(NREGS));

  logic [7:0] rd_byte;
  always_comb begin
    if (ptr == 8'd0)                rd_byte = {dev_addr, 1'b0};
    else if (ptr == 8'd1)           rd_byte = status_i;
    else if (ptr_rw)                rd_byte = regs[ptr[AW-1:0]];
    else                            rd_byte = 8'h00;
  end

  assign sda_oe = (st == S_AACK) | (st == S_PACK) | (st == S_WACK) |
                  ((st == S_RDAT) & ~sh[7]);

  for (genvar g = 2; g < NREGS; g++) begin : g_out
    assign ctrl_o[(g-2)*8 +: 8] = regs[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 3'b111;
      sda_sy <= 3'b111;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
    end else if (scl_s & sda_s) begin
      if (idle_cnt != IW'(IDLE_CYC - 1)) idle_cnt <= idle_cnt + 1'b1;
    end else begin
      idle_cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bitn      <= '0;
      sh        <= '0;
      ptr       <= '0;
      rw        <= 1'b0;
      dev_addr  <= DEF_ADDR;
      chain_out <= 1'b0;
      for (int i = 2; i < NREGS; i++) regs[i] <= 8'h00;
    end else if (start_det) begin
      st   <= S_ADDR;
      bitn <= '0;
    end else if (stop_det | idle_hit) begin
      st <= S_IDLE;
    end else begin
      unique case (st)
        S_ADDR, S_PTR, S_WDAT: begin
          if (rise) begin
            sh   <= {sh[6:0], sda_s};
            bitn <= bitn + 1'b1;
          end else if (byte_end) begin
            bitn <= '0;
            if (st == S_ADDR) begin
              if (sh[7:1] == dev_addr) begin
                st <= S_AACK;
                rw <= sh[0];
              end else begin
                st <= S_IGNORE;
              end
            end else if (st == S_PTR) begin
              ptr <= sh;
              st  <= S_PACK;
            end else begin
              st <= S_WACK;
              if (ptr == 8'd0) begin
                dev_addr  <= sh[7:1];
                chain_out <= 1'b1;
              end else if (ptr_rw) begin
                regs[ptr[AW-1:0]] <= sh;
              end
            end
          end
        end
        S_AACK: if (fall) begin
          bitn <= '0;
          if (rw) begin
            st <= S_RDAT;
            sh <= rd_byte;
          end else begin
            st <= S_PTR;
          end
        end
        S_PACK: if (fall) st <= S_WDAT;
        S_WACK: if (fall) st <= S_IGNORE;
        S_RDAT: begin
          if (rise) bitn <= bitn + 1'b1;
          else if (byte_end) st <= S_RACK;
          else if (fall) sh <= {sh[6:0], 1'b0};
        end
        S_RACK: if (fall) st <= S_IGNORE;
        default: ;
      endcase
    end
  end

  AST_CHAIN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    chain_out |=> chain_out); // R5

  AST_ADDR_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_out |-> dev_addr == DEF_ADDR); // R6

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE || st == S_IGNORE || st == S_RACK) |-> !sda_oe); // R11

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> st == S_IDLE); // R9

  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> st == S_ADDR); // R9

  AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_hit && !start_det) |=> st == S_IDLE); // R10

  AST_MISS_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR && byte_end && sh[7:1] != dev_addr && !start_det && !stop_det && !idle_hit)
    |=> st == S_IGNORE); // R7
endmodule

// File: tb/test_smbus_chain_target.sv
module test_smbus_chain_target;
  localparam int NREGS = 8;
  localparam int HP    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, chain_out;
  logic [7:0] status_i = 8'h00;
  logic [8*(NREGS-2)-1:0] ctrl_o;
  wire  sda_line = sda_m & ~sda_oe;

  int total = 0, bad = 0;
  logic [7:0] model [0:NREGS-1];
  logic [6:0] m_addr;

  always #2 clk = ~clk;

  smbus_chain_target #(.NREGS(NREGS), .DEF_ADDR(7'h17), .IDLE_CYC(64)) i_smbus_chain_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .status_i(status_i), .ctrl_o(ctrl_o), .chain_out(chain_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic b_start();
    sda_m = 1'b1; w(HP); scl_m = 1'b1; w(HP); sda_m = 1'b0; w(HP); scl_m = 1'b0; w(HP);
  endtask

  task automatic b_stop();
    sda_m = 1'b0; w(HP); scl_m = 1'b1; w(HP); sda_m = 1'b1; w(HP);
  endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(HP); scl_m = 1'b1; w(HP); scl_m = 1'b0;
    end
    sda_m = 1'b1; w(HP); scl_m = 1'b1; w(HP/2); ack = !sda_line; w(HP/2); scl_m = 1'b0;
  endtask

  task automatic recv(output logic [7:0] b, output bit rel);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(HP); scl_m = 1'b1; w(HP/2); b[i] = sda_line; w(HP/2); scl_m = 1'b0;
    end
    w(HP); scl_m = 1'b1; w(HP/2); rel = sda_line; w(HP/2); scl_m = 1'b0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d,
                    output bit a1, output bit a2, output bit a3);
    b_start(); send({a, 1'b0}, a1); send(p, a2); send(d, a3); b_stop();
  endtask

  task automatic rd(input logic [6:0] a, input logic [7:0] p, output logic [7:0] d,
                    output bit acks, output bit rel);
    bit x1, x2, x3;
    b_start(); send({a, 1'b0}, x1); send(p, x2);
    b_start(); send({a, 1'b1}, x3); recv(d, rel); b_stop();
    acks = x1 & x2 & x3;
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] p);
    if (p == 0) return {m_addr, 1'b0};
    if (p == 1) return status_i;
    if (p < NREGS) return model[p];
    return 8'h00;
  endfunction

  function automatic void m_wr(input logic [7:0] p, input logic [7:0] d);
    if (p == 0) m_addr = d[7:1];
    else if (p >= 2 && p < NREGS) model[p] = d;
  endfunction

  function automatic logic [8*(NREGS-2)-1:0] exp_ctrl();
    logic [8*(NREGS-2)-1:0] v;
    for (int i = 2; i < NREGS; i++) v[(i-2)*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic model_reset();
    m_addr = 7'h17;
    for (int i = 0; i < NREGS; i++) model[i] = 8'h00;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit a1, a2, a3, ok, rel;
    logic [7:0] d, p, v;
    void'($urandom(32'd1234));
    model_reset();
    w(5); rst_n = 1'b1; w(5);

    chk(!chain_out, "R1 chain low after reset", chain_out, 0);
    chk(ctrl_o == '0, "R6 ctrl defaults", 0, 0);
    rd(7'h17, 8'h00, d, ok, rel);
    chk(ok && d == 8'h2E, "R1 default address read", d, 8'h2E);

    wr(7'h17, 8'h03, 8'hA5, a1, a2, a3); m_wr(8'h03, 8'hA5);
    chk(a1 & a2 & a3, "R2 write acks", {a1, a2, a3}, 7);
    chk(ctrl_o == exp_ctrl(), "R2 ctrl after write", ctrl_o[15:8], 8'hA5);
    rd(7'h17, 8'h03, d, ok, rel);
    chk(ok && d == 8'hA5, "R3 read back", d, 8'hA5);
    chk(rel, "R3 SDA released on master ack", rel, 1);

    for (int it = 0; it < 40; it++) begin
      p = 8'($urandom_range(1, NREGS + 2));
      v = 8'($urandom);
      status_i = 8'($urandom);
      if ($urandom_range(0, 1) == 1) begin
        wr(7'h17, p, v, a1, a2, a3); m_wr(p, v);
        chk(a1 & a2 & a3, "R2/R8 random write acks", {a1, a2, a3}, 7);
        chk(ctrl_o == exp_ctrl(), "R2/R8 random ctrl", p, v);
      end else begin
        rd(7'h17, p, d, ok, rel);
        chk(ok && d == exp_rd(p), "R3/R8 random read", d, exp_rd(p));
      end
    end

    wr(7'h17, 8'h01, 8'h5A, a1, a2, a3);
    chk(a1 & a2 & a3 && ctrl_o == exp_ctrl(), "R8 write to read-only acked no effect", a3, 1);
    wr(7'h17, 8'hF0, 8'h77, a1, a2, a3);
    rd(7'h17, 8'hF0, d, ok, rel);
    chk(a3 && ok && d == 8'h00 && ctrl_o == exp_ctrl(), "R8 unmapped reads zero", d, 0);

    wr(7'h2A, 8'h04, 8'h99, a1, a2, a3);
    chk(!a1 && !a2 && !a3, "R7 wrong address no ack", {a1, a2, a3}, 0);
    chk(ctrl_o == exp_ctrl(), "R7 wrong address no effect", ctrl_o[23:16], model[4]);

    b_start(); send({7'h17, 1'b0}, a1);
    sda_m = 1'b1; w(HP); scl_m = 1'b1; w(100);
    scl_m = 1'b0; w(HP);
    send(8'h05, a2); send(8'h3C, a3); b_stop();
    chk(a1 && !a2 && !a3, "R10 timeout abandons transaction", {a1, a2, a3}, 4);
    chk(ctrl_o == exp_ctrl(), "R10 no write after timeout", ctrl_o[31:24], model[5]);

    b_start(); send({7'h17, 1'b0}, a1); b_stop();
    b_start(); send({7'h17, 1'b0}, a1); send(8'h06, a2); b_start();
    send({7'h17, 1'b0}, a3); send(8'h06, ok); send(8'h42, rel); b_stop(); m_wr(8'h06, 8'h42);
    chk(a1 && a3 && ok && rel && ctrl_o == exp_ctrl(), "R9 repeated START restarts", ctrl_o[39:32], 8'h42);

    chk(!chain_out, "R5 chain low before reg0 write", chain_out, 0);
    wr(7'h17, 8'h00, 8'h2C, a1, a2, a3); m_wr(8'h00, 8'h2C);
    chk(a3 && chain_out, "R5 chain rises on reg0 write", chain_out, 1);
    wr(7'h17, 8'h02, 8'h11, a1, a2, a3);
    chk(!a1 && ctrl_o == exp_ctrl(), "R4 old address ignored", a1, 0);
    rd(7'h16, 8'h00, d, ok, rel);
    chk(ok && d == 8'h2C, "R4 new address answers", d, 8'h2C);
    wr(7'h16, 8'h02, 8'h11, a1, a2, a3); m_wr(8'h02, 8'h11);
    chk(a1 && chain_out && ctrl_o == exp_ctrl(), "R5 chain stays high", chain_out, 1);

    w(3); rst_n = 1'b0; w(3);
    chk(!chain_out && ctrl_o == '0, "R6 reset forces defaults", chain_out, 0);
    rst_n = 1'b1; w(5); model_reset();
    rd(7'h17, 8'h02, d, ok, rel);
    chk(ok && d == 8'h00, "R6 default address after reset", d, 0);
    rd(7'h16, 8'h00, d, ok, rel);
    chk(!ok, "R6 programmed address lost", ok, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule